// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Postponement

This block tells a memory controller when DRAM refresh commands are due. A free-running interval timer adds one owed refresh every `INTERVAL` clock cycles (the default of 1040 cycles is the 7.8 us average refresh period at a 7.5 ns clock). Owed refreshes are kept in a signed balance. A positive value is debt. A negative value is credit, earned by refreshing ahead of schedule. Either way the balance is held to at most `MAX_DEBT` (8) refreshes. The scheduler raises a normal request while debt is owed, and an urgent request once the debt ceiling is reached.

The controller issues a refresh only while the scheduler shows refresh-ready. That signal needs all banks precharged (the all-idle input), no refresh cycle time still running, no self-refresh in progress, and room left for more credit. The controller then pulses the issue strobe. A self-refresh entry strobe, also gated by refresh-ready, stops the interval timer until an exit strobe arrives. After exit, separate counters hold off row activates for `TXSA` cycles and reads for `TXSR` cycles.

Top module: `refresh_sched`

## Requirements
- R1: After reset the balance is zero and the timers are idle. So `req` and `urgent` are 0, `readyAct` and `readyRd` are 1, and `refOk` follows `allIdle`.
- R2: Outside self-refresh, the balance rises by one every `INTERVAL` cycles, first at the `INTERVAL`-th rising edge after reset. `req` is 1 exactly while the balance is above zero and the block is not in self-refresh.
- R3: The balance never exceeds `MAX_DEBT`, and an interval tick at the ceiling is dropped. `urgent` is 1 exactly while the balance equals `MAX_DEBT` outside self-refresh, and it clears once the balance drops below it.
- R4: An `ack` sampled high while `refOk` is 1 lowers the balance by one; a tick in the same cycle cancels it. An `ack` sampled while `refOk` is 0 has no effect.
- R5: Refreshes issued with no debt become credit, down to a balance of minus `MAX_DEBT`. `req` stays 0 until later ticks use up the credit. `refOk` is 0 while the credit is full.
- R6: `refOk` is 0 whenever `allIdle` is 0.
- R7: After an accepted `ack`, `refOk`, `readyAct` and `readyRd` are 0 for the next `TRFC` cycles.
- R8: `srEnter` takes effect only while `refOk` is 1. In self-refresh the interval timer holds its value, and `req`, `urgent`, `refOk`, `readyAct` and `readyRd` are all 0. `srExit` outside self-refresh has no effect.
- R9: After an accepted `srExit`, `readyAct` and `refOk` stay 0 for `TXSA` cycles.
- R10: After an accepted `srExit`, `readyRd` stays 0 for `TXSR` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| allIdle | input | 1 | All banks are precharged |
| ack | input | 1 | One refresh command issued this cycle |
| srEnter | input | 1 | Refresh issued with clock enable low (self-refresh entry) |
| srExit | input | 1 | Clock enable raised (self-refresh exit) |
| req | output | 1 | Refresh owed |
| urgent | output | 1 | Debt ceiling reached |
| refOk | output | 1 | A refresh or self-refresh entry may be issued now |
| readyAct | output | 1 | Row activate allowed |
| readyRd | output | 1 | Read allowed |

## Verification
The embedded properties check on every cycle that the balance stays inside its bounds, that urgent implies request, and that the all-idle input gates refresh-ready. They also check that an accepted refresh blocks the next cycle, that self-refresh silences every output, that the timer freezes in self-refresh, and that exit blocks activates. The exact arithmetic of the balance needs the bench's scenarios: a tick and an issue cancelling in the same cycle, saturation at both ends, and credit holding back later requests. So do the exact lengths of the refresh-cycle, activate and read hold-off windows. The bench's reference model follows all of these cycle by cycle.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic tickEn;    // interval timer may advance
    logic ackTake;   // accepted refresh command
    logic exitTake;  // accepted self-refresh exit
  } strobe_t;
endpackage

// File: rtl/refresh_down.sv
module refresh_down #(
  parameter int LOAD = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(LOAD + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (load)        cnt <= CW'(LOAD);
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/refresh_dp.sv
module refresh_dp
  import refresh_pkg::*;
#(
  parameter int INTERVAL = 1040,
  parameter int MAX_DEBT = 8,
  parameter int TRFC     = 10,
  parameter int TXSA     = 10,
  parameter int TXSR     = 200,
  localparam int BAL_W   = $clog2(MAX_DEBT + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  output logic signed [BAL_W-1:0] balance,
  output logic                    rfcBusy,
  output logic                    xsaBusy,
  output logic                    xsrBusy
);
  localparam int TICK_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic signed [BAL_W-1:0] BAL_MAX = BAL_W'(MAX_DEBT);
  localparam logic signed [BAL_W-1:0] BAL_MIN = -BAL_MAX;

  logic [TICK_W-1:0] tickCnt;
  logic              tickFire;

  assign tickFire = strobe.tickEn && (tickCnt == TICK_W'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             tickCnt <= '0;
    else if (strobe.tickEn) tickCnt <= tickFire ? '0 : tickCnt + TICK_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) balance <= '0;
    else if (tickFire && !strobe.ackTake) begin
      if (balance < BAL_MAX) balance <= balance + BAL_W'(1);
    end else if (strobe.ackTake && !tickFire) begin
      if (balance > BAL_MIN) balance <= balance - BAL_W'(1);
    end
  end

  // three hold-off windows share one counter shape
  localparam int NWIN = 3;
  localparam int WIN_LEN [NWIN] = '{TRFC, TXSA, TXSR};
  logic [NWIN-1:0] winLoad, winBusy;
  assign winLoad = {strobe.exitTake, strobe.exitTake, strobe.ackTake};

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    refresh_down #(.LOAD(WIN_LEN[w])) u_win (
      .clk(clk), .rstN(rstN), .load(winLoad[w]), .busy(winBusy[w]));
  end

  assign rfcBusy = winBusy[0];
  assign xsaBusy = winBusy[1];
  assign xsrBusy = winBusy[2];

  p_balance_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    (balance <= BAL_MAX) && (balance >= BAL_MIN));
  p_timer_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.tickEn |=> (tickCnt == $past(tickCnt)));
  p_ack_starts_rfc_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackTake |=> rfcBusy);
endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int MAX_DEBT = 8,
  localparam int BAL_W   = $clog2(MAX_DEBT + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    allIdle,
  input  logic                    ack,
  input  logic                    srEnter,
  input  logic                    srExit,
  input  logic signed [BAL_W-1:0] balance,
  input  logic                    rfcBusy,
  input  logic                    xsaBusy,
  input  logic                    xsrBusy,
  output strobe_t                 strobe,
  output logic                    req,
  output logic                    urgent,
  output logic                    refOk,
  output logic                    readyAct,
  output logic                    readyRd
);
  localparam logic signed [BAL_W-1:0] BAL_MAX = BAL_W'(MAX_DEBT);
  localparam logic signed [BAL_W-1:0] BAL_MIN = -BAL_MAX;

  logic inSr;
  logic srTake;

  assign req      = !inSr && (balance > 0);
  assign urgent   = !inSr && (balance == BAL_MAX);
  assign refOk    = allIdle && !inSr && !rfcBusy && !xsaBusy && (balance > BAL_MIN);
  assign readyAct = !inSr && !rfcBusy && !xsaBusy;
  assign readyRd  = !inSr && !rfcBusy && !xsrBusy;

  assign srTake          = srEnter && refOk;
  assign strobe.ackTake  = ack && refOk;
  assign strobe.exitTake = srExit && inSr;
  assign strobe.tickEn   = !inSr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                inSr <= 1'b0;
    else if (strobe.exitTake) inSr <= 1'b0;
    else if (srTake)          inSr <= 1'b1;
  end

  p_urgent_has_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    urgent |-> req);
  p_idle_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    !allIdle |-> !refOk);
  p_rfc_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ack && refOk) |=> (!refOk && !readyAct && !readyRd));
  p_sr_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    inSr |-> (!req && !urgent && !refOk && !readyAct && !readyRd));
  p_exit_holds_act_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inSr && srExit) |=> (!readyAct && !refOk));
  p_exit_holds_rd_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inSr && srExit) |=> !readyRd);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int INTERVAL = 1040,
  parameter int MAX_DEBT = 8,
  parameter int TRFC     = 10,
  parameter int TXSA     = 10,
  parameter int TXSR     = 200
) (
  input  logic clk,
  input  logic rstN,
  input  logic allIdle,
  input  logic ack,
  input  logic srEnter,
  input  logic srExit,
  output logic req,
  output logic urgent,
  output logic refOk,
  output logic readyAct,
  output logic readyRd
);
  localparam int BAL_W = $clog2(MAX_DEBT + 1) + 1;

  strobe_t                 strobe;
  logic signed [BAL_W-1:0] balance;
  logic                    rfcBusy, xsaBusy, xsrBusy;

  refresh_ctrl #(.MAX_DEBT(MAX_DEBT)) u_ctrl (
    .clk(clk), .rstN(rstN), .allIdle(allIdle), .ack(ack),
    .srEnter(srEnter), .srExit(srExit), .balance(balance),
    .rfcBusy(rfcBusy), .xsaBusy(xsaBusy), .xsrBusy(xsrBusy),
    .strobe(strobe), .req(req), .urgent(urgent), .refOk(refOk),
    .readyAct(readyAct), .readyRd(readyRd));

  refresh_dp #(.INTERVAL(INTERVAL), .MAX_DEBT(MAX_DEBT), .TRFC(TRFC),
               .TXSA(TXSA), .TXSR(TXSR)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .balance(balance),
    .rfcBusy(rfcBusy), .xsaBusy(xsaBusy), .xsrBusy(xsrBusy));
endmodule

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
  localparam int N    = 16;
  localparam int MAXD = 8;
  localparam int TRFC = 3;
  localparam int TXSA = 4;
  localparam int TXSR = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allIdle = 1'b1, ack = 1'b0, srEnter = 1'b0, srExit = 1'b0;
  logic req, urgent, refOk, readyAct, readyRd;

  int compared = 0, mismatched = 0, cycles = 0;
  bit running = 1'b0;

  // reference model state
  int mTick = 0, mBal = 0, mRfc = 0, mXsa = 0, mXsr = 0;
  bit mSr = 1'b0;

  always #5 clk = ~clk;

  refresh_sched #(.INTERVAL(N), .MAX_DEBT(MAXD), .TRFC(TRFC),
                  .TXSA(TXSA), .TXSR(TXSR)) u_refresh_sched (
    .clk(clk), .rstN(rstN), .allIdle(allIdle), .ack(ack),
    .srEnter(srEnter), .srExit(srExit), .req(req), .urgent(urgent),
    .refOk(refOk), .readyAct(readyAct), .readyRd(readyRd));

  function automatic bit mRefOk();
    return allIdle && !mSr && mRfc == 0 && mXsa == 0 && mBal > -MAXD;
  endfunction

  always @(posedge clk) begin
    if (rstN) begin
      bit ok, ackT, srT, exT, tickF;
      ok    = mRefOk();
      ackT  = ack && ok;
      srT   = srEnter && ok;
      exT   = srExit && mSr;
      tickF = !mSr && (mTick == N - 1);
      if (!mSr) mTick = tickF ? 0 : mTick + 1;
      if (tickF && !ackT && mBal < MAXD) mBal++;
      else if (ackT && !tickF && mBal > -MAXD) mBal--;
      mRfc = ackT ? TRFC : (mRfc > 0 ? mRfc - 1 : 0);
      mXsa = exT ? TXSA : (mXsa > 0 ? mXsa - 1 : 0);
      mXsr = exT ? TXSR : (mXsr > 0 ? mXsr - 1 : 0);
      if (exT) mSr = 1'b0;
      else if (srT) mSr = 1'b1;
    end
  end

  task automatic check(string tag, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (running) begin
      check("R2/R5 req",       req,      !mSr && mBal > 0);
      check("R3 urgent",       urgent,   !mSr && mBal == MAXD);
      check("R4/R6/R7 refOk",  refOk,    mRefOk());
      check("R7/R9 readyAct",  readyAct, !mSr && mRfc == 0 && mXsa == 0);
      check("R8/R10 readyRd",  readyRd,  !mSr && mRfc == 0 && mXsr == 0);
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); #1 sig = 1'b1;
    @(negedge clk); #1 sig = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 req",      req,      1'b0);
    check("R1 urgent",   urgent,   1'b0);
    check("R1 readyAct", readyAct, 1'b1);
    check("R1 readyRd",  readyRd,  1'b1);
    check("R1 refOk",    refOk,    1'b1);
    running = 1'b1;

    // R2, R3: let debt build past the ceiling, banks busy part of the time
    waitCyc(3 * N);
    #1 allIdle = 1'b0;               // R6: refOk must drop
    pulse(ack);                      // R4: ignored while not ready
    waitCyc(7 * N);
    check("R3 urgent at ceiling", urgent, 1'b1);
    #1 allIdle = 1'b1;

    // R4, R7: issue refreshes, some during tRFC (ignored)
    for (int i = 0; i < 4; i++) begin
      pulse(ack);
      pulse(ack);                    // lands inside tRFC window
      waitCyc(TRFC);
    end
    check("R3 urgent cleared", urgent, 1'b0);

    // R5: pay off debt then build credit to the limit
    for (int i = 0; i < 20; i++) begin
      pulse(ack);
      waitCyc(TRFC);
    end
    check("R5 credit blocks req", req, 1'b0);
    waitCyc(2 * N);
    check("R5 req still held by credit", req, 1'b0);

    // R8: exit outside self-refresh is ignored; entry with banks busy ignored
    pulse(srExit);
    #1 allIdle = 1'b0;
    pulse(srEnter);
    #1 allIdle = 1'b1;
    waitCyc(2);
    check("R8 entry ignored", readyAct, 1'b1);

    // R8: enter self-refresh, stay several intervals
    pulse(srEnter);
    waitCyc(5 * N);
    check("R8 quiet in self-refresh", readyRd, 1'b0);
    pulse(srEnter);                  // ignored while inside
    // R9, R10: exit and watch hold-offs
    pulse(srExit);
    waitCyc(TXSR + 4);
    check("R10 read allowed after hold-off", readyRd, 1'b1);

    // debt grows again after exit; combined tick/ack cancel exercised
    for (int i = 0; i < 12; i++) begin
      waitCyc(N - 2 + (i % 3));
      pulse(ack);
    end
    waitCyc(N * 10);

    running = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule